// File: doc/BRIEF.md
# Flash Block Write-Protect Arbiter

This block sits between the command decoder of a flash array and the erase/program engine. For each modify request it decides, in one clock, whether the operation may go ahead on the addressed block. It raises a single-cycle enable pulse when the operation is allowed and a single-cycle device-protect error pulse when it is refused. The decision follows a fixed priority chain:

- program-supply lockout first,
- then the chip reset pin,
- then the permanent lock-bit (for lock-bit configuration only),
- then the per-block lock-bits,
- and last the write-protect pin, which guards only the two boot blocks.

A strap sampled while the block is held in reset places those two boot blocks at the top or the bottom of the array.

A full-chip erase is not enabled as a single action. The arbiter takes a snapshot of which blocks are erasable and then walks all block indices in ascending order, one index per clock. It issues a one-hot erase strobe only for the blocks in the snapshot and pulses a done flag once the sweep ends. If the supply drops into lockout or the reset pin falls during the walk, the sweep aborts and the arbiter reports a protect error.

Top module: `flash_wp_arbiter`

## Requirements
- R1: The two boot blocks are indices N-1 and N-2 when the strap sampled during reset was 1, and indices 0 and 1 when it was 0. Write-protect (`wpN` low) locks those two blocks only; no other block is affected by it.
- R2: While `supplyLow` is 1, every accepted request is refused with a protect error, whatever the other inputs are.
- R3: While `resetPinN` is 0, every accepted request is refused with a protect error, whatever the other inputs are.
- R4: Block erase (op 0) and word/byte write (op 1) are refused when the target block's lock-bit is 1. They are also refused when the target is a boot block and `wpN` is 0. Otherwise they are enabled. A target index at or above N is refused.
- R5: An enabled full-chip erase (op 2) visits indices 0 to N-1 in order, one per clock, starting in the cycle after acceptance. Index k raises `eraseStrobe[k]` (one-hot) only if block k was erasable when the request was accepted: its lock-bit was 0, and it was not a boot block while `wpN` was 0.
- R6: Set block lock-bit (op 3) and clear block lock-bits (op 4) are enabled only when `permLock` is 0.
- R7: Set permanent lock-bit (op 5) is enabled whenever the supply is above lockout and `resetPinN` is 1. No lock state affects it.
- R8: A request is accepted on a clock edge where `reqValid` is 1, the op code is 0 to 5, and no sweep is running. In the following cycle exactly one of `opEnable` (allowed) or `protectErr` (refused) is 1, for that cycle only. After reset both are 0, and no strobe or busy is active.
- R9: `sweepBusy` is 1 for exactly the N cycles of the walk. `sweepDone` pulses for one cycle directly after the last index, with `sweepBusy` already 0.
- R10: A full-chip erase that finds no erasable block is refused with `protectErr`. It issues no strobe and never sets `sweepBusy`.
- R11: A request presented while a sweep is running, or carrying op code 6 or 7, is ignored: it produces no enable and no error in the next cycle.
- R12: If `supplyLow` rises or `resetPinN` falls during a sweep, strobes stop at once. The sweep then ends with a `protectErr` pulse and no `sweepDone`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset; strap is captured while low |
| reqValid | input | 1 | Request presented this cycle |
| reqOp | input | 3 | Operation code (0 erase, 1 write, 2 chip erase, 3 set lock, 4 clear locks, 5 set permanent lock) |
| reqBlock | input | $clog2(N) | Target block index for ops 0 and 1 |
| supplyLow | input | 1 | Program supply at or below lockout |
| resetPinN | input | 1 | Chip reset pin, low denies all |
| wpN | input | 1 | Write-protect pin, low protects the boot blocks |
| permLock | input | 1 | Permanent lock-bit |
| blockLocks | input | N | Per-block lock-bits |
| bootTopStrap | input | 1 | Boot configuration strap, 1 = boot blocks at top |
| opEnable | output | 1 | Operation allowed pulse |
| protectErr | output | 1 | Device-protect error pulse |
| eraseStrobe | output | N | One-hot erase strobe during full-chip sweep |
| sweepBusy | output | 1 | Full-chip sweep in progress |
| sweepDone | output | 1 | Sweep completed pulse |

## Verification
The hardest situation to reach is an abort in the middle of a sweep. Getting there needs a full-chip erase that has been accepted with a non-empty erasable set, followed by a lockout that arrives only after some strobes have already been issued. The bench starts a sweep with every block unlocked and checks the first strobes one by one. It then raises the supply-lockout input between two clock edges, so the strobe must vanish in that same cycle and the error must follow at the next edge. A second targeted run presents an otherwise-allowed block erase in the middle of a sweep to show that it is dropped while the walk carries on undisturbed. Everything else comes from a near-exhaustive sweep of op, block, lock pattern and pin levels under both strap settings.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

  localparam logic [2:0] OP_BLK_ERASE  = 3'd0;
  localparam logic [2:0] OP_WRITE      = 3'd1;
  localparam logic [2:0] OP_CHIP_ERASE = 3'd2;
  localparam logic [2:0] OP_SET_LOCK   = 3'd3;
  localparam logic [2:0] OP_CLR_LOCKS  = 3'd4;
  localparam logic [2:0] OP_SET_PERM   = 3'd5;
  localparam logic [2:0] OP_LAST_VALID = 3'd5;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSweep;  // snapshot erasable set, clear index
    logic stepIdx;    // advance sweep index
  } dp_ctl_t;

endpackage

// File: rtl/fwp_datapath.sv
module fwp_datapath
  import fwp_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            reqOp,
  input  logic [BLK_W-1:0]      reqBlock,
  input  logic                  supplyLow,
  input  logic                  resetPinN,
  input  logic                  wpN,
  input  logic                  permLock,
  input  logic [NUM_BLOCKS-1:0] blockLocks,
  input  logic                  bootTopStrap,
  input  dp_ctl_t               ctl,
  input  logic                  sweeping,
  output logic                  gateOpen,
  output logic                  opKnown,
  output logic                  isChipErase,
  output logic                  reqAllowed,
  output logic                  lastIdx,
  output logic [NUM_BLOCKS-1:0] eraseStrobe
);

  localparam logic [BLK_W:0]   NB_EXT   = NUM_BLOCKS[BLK_W:0];
  localparam logic [BLK_W-1:0] LAST_IDX = BLK_W'(NUM_BLOCKS - 1);

  logic                  bootTopQ;
  logic [NUM_BLOCKS-1:0] bootMask;
  logic [NUM_BLOCKS-1:0] lockedVec;
  logic [NUM_BLOCKS-1:0] erasable;
  logic [NUM_BLOCKS-1:0] sweepMask;
  logic [BLK_W-1:0]      sweepIdx;
  logic                  targetInRange;
  logic                  targetLocked;

  // strap is captured only while the block is held in reset
  always_ff @(posedge clk) begin
    if (!rst_n) bootTopQ <= bootTopStrap;
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    localparam bit IS_HI = (b >= NUM_BLOCKS - 2);
    localparam bit IS_LO = (b < 2);
    assign bootMask[b]    = bootTopQ ? IS_HI : IS_LO;
    assign eraseStrobe[b] = sweeping && gateOpen && sweepMask[b]
                            && (sweepIdx == BLK_W'(b));
  end

  assign gateOpen      = !supplyLow && resetPinN;
  assign lockedVec     = blockLocks | (bootMask & {NUM_BLOCKS{~wpN}});
  assign erasable      = gateOpen ? ~lockedVec : '0;
  assign targetInRange = {1'b0, reqBlock} < NB_EXT;
  assign targetLocked  = lockedVec[reqBlock];
  assign opKnown       = reqOp <= OP_LAST_VALID;
  assign isChipErase   = reqOp == OP_CHIP_ERASE;
  assign lastIdx       = sweepIdx == LAST_IDX;

  always_comb begin
    unique case (reqOp)
      OP_BLK_ERASE,
      OP_WRITE:      reqAllowed = gateOpen && targetInRange && !targetLocked;
      OP_CHIP_ERASE: reqAllowed = |erasable;
      OP_SET_LOCK,
      OP_CLR_LOCKS:  reqAllowed = gateOpen && !permLock;
      OP_SET_PERM:   reqAllowed = gateOpen;
      default:       reqAllowed = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sweepMask <= '0;
      sweepIdx  <= '0;
    end else if (ctl.loadSweep) begin
      sweepMask <= erasable;
      sweepIdx  <= '0;
    end else if (ctl.stepIdx) begin
      sweepIdx  <= sweepIdx + 1'b1;
    end
  end

endmodule

// File: rtl/fwp_ctrl.sv
module fwp_ctrl
  import fwp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    opKnown,
  input  logic    isChipErase,
  input  logic    reqAllowed,
  input  logic    gateOpen,
  input  logic    lastIdx,
  output dp_ctl_t ctl,
  output logic    sweeping,
  output logic    opEnable,
  output logic    protectErr,
  output logic    sweepDone
);

  sweep_state_e state;
  logic         accept;

  assign sweeping = state == ST_SWEEP;
  assign accept   = reqValid && opKnown && (state == ST_IDLE);

  always_comb begin
    ctl.loadSweep = accept && isChipErase && reqAllowed;
    ctl.stepIdx   = sweeping && gateOpen && !lastIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      opEnable   <= 1'b0;
      protectErr <= 1'b0;
      sweepDone  <= 1'b0;
    end else begin
      opEnable   <= 1'b0;
      protectErr <= 1'b0;
      sweepDone  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            opEnable   <= reqAllowed;
            protectErr <= !reqAllowed;
            if (ctl.loadSweep) state <= ST_SWEEP;
          end
        end
        ST_SWEEP: begin
          if (!gateOpen) begin
            state      <= ST_IDLE;
            protectErr <= 1'b1;
          end else if (lastIdx) begin
            state      <= ST_IDLE;
            sweepDone  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_wp_arbiter.sv
module flash_wp_arbiter
  import fwp_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reqValid,
  input  logic [2:0]            reqOp,
  input  logic [BLK_W-1:0]      reqBlock,
  input  logic                  supplyLow,
  input  logic                  resetPinN,
  input  logic                  wpN,
  input  logic                  permLock,
  input  logic [NUM_BLOCKS-1:0] blockLocks,
  input  logic                  bootTopStrap,
  output logic                  opEnable,
  output logic                  protectErr,
  output logic [NUM_BLOCKS-1:0] eraseStrobe,
  output logic                  sweepBusy,
  output logic                  sweepDone
);

  dp_ctl_t ctl;
  logic    sweeping;
  logic    gateOpen;
  logic    opKnown;
  logic    isChipErase;
  logic    reqAllowed;
  logic    lastIdx;

  fwp_datapath #(.NUM_BLOCKS(NUM_BLOCKS)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqOp        (reqOp),
    .reqBlock     (reqBlock),
    .supplyLow    (supplyLow),
    .resetPinN    (resetPinN),
    .wpN          (wpN),
    .permLock     (permLock),
    .blockLocks   (blockLocks),
    .bootTopStrap (bootTopStrap),
    .ctl          (ctl),
    .sweeping     (sweeping),
    .gateOpen     (gateOpen),
    .opKnown      (opKnown),
    .isChipErase  (isChipErase),
    .reqAllowed   (reqAllowed),
    .lastIdx      (lastIdx),
    .eraseStrobe  (eraseStrobe)
  );

  fwp_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .opKnown     (opKnown),
    .isChipErase (isChipErase),
    .reqAllowed  (reqAllowed),
    .gateOpen    (gateOpen),
    .lastIdx     (lastIdx),
    .ctl         (ctl),
    .sweeping    (sweeping),
    .opEnable    (opEnable),
    .protectErr  (protectErr),
    .sweepDone   (sweepDone)
  );

  assign sweepBusy = sweeping;

endmodule

// File: rtl/fwp_checker.sv
module fwp_checker #(
  parameter int NUM_BLOCKS = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reqValid,
  input logic [2:0]            reqOp,
  input logic                  supplyLow,
  input logic                  resetPinN,
  input logic                  permLock,
  input logic                  opEnable,
  input logic                  protectErr,
  input logic [NUM_BLOCKS-1:0] eraseStrobe,
  input logic                  sweepBusy,
  input logic                  sweepDone
);

  p_result_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(opEnable && protectErr));

  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eraseStrobe));

  p_no_strobe_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sweepBusy |-> (eraseStrobe == '0));

  p_lockout_denies_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !sweepBusy && reqOp <= 3'd5 && supplyLow)
    |=> (protectErr && !opEnable));

  p_resetpin_denies_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !sweepBusy && reqOp <= 3'd5 && !resetPinN)
    |=> (protectErr && !opEnable));

  p_perm_blocks_lockcfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !sweepBusy && (reqOp == 3'd3 || reqOp == 3'd4) && permLock)
    |=> !opEnable);

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweepDone) |-> ($past(sweepBusy) && !sweepBusy));

  p_busy_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && sweepBusy && !supplyLow && resetPinN) |=> !opEnable && !protectErr);

  p_abort_no_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sweepBusy && (supplyLow || !resetPinN)) |=> (!sweepDone && !sweepBusy && protectErr));

endmodule

bind flash_wp_arbiter fwp_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_fwp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .reqOp       (reqOp),
  .supplyLow   (supplyLow),
  .resetPinN   (resetPinN),
  .permLock    (permLock),
  .opEnable    (opEnable),
  .protectErr  (protectErr),
  .eraseStrobe (eraseStrobe),
  .sweepBusy   (sweepBusy),
  .sweepDone   (sweepDone)
);

// File: tb/flash_wp_arbiter_bench.sv
module flash_wp_arbiter_bench;

  localparam int NB = 8;
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0;
  logic [2:0]    reqOp = '0;
  logic [BW-1:0] reqBlock = '0;
  logic          supplyLow = 1'b0;
  logic          resetPinN = 1'b1;
  logic          wpN = 1'b1;
  logic          permLock = 1'b0;
  logic [NB-1:0] blockLocks = '0;
  logic          bootTopStrap = 1'b0;
  logic          opEnable;
  logic          protectErr;
  logic [NB-1:0] eraseStrobe;
  logic          sweepBusy;
  logic          sweepDone;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  flash_wp_arbiter #(.NUM_BLOCKS(NB)) u_flash_wp_arbiter (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .reqBlock(reqBlock), .supplyLow(supplyLow), .resetPinN(resetPinN),
    .wpN(wpN), .permLock(permLock), .blockLocks(blockLocks),
    .bootTopStrap(bootTopStrap), .opEnable(opEnable), .protectErr(protectErr),
    .eraseStrobe(eraseStrobe), .sweepBusy(sweepBusy), .sweepDone(sweepDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit isBoot(input int b, input bit top);
    return top ? (b >= NB - 2) : (b < 2);
  endfunction

  function automatic logic [NB-1:0] expErasable(input bit top, input bit wp,
                                                input logic [NB-1:0] locks);
    logic [NB-1:0] m;
    for (int b = 0; b < NB; b++)
      m[b] = !locks[b] && !(isBoot(b, top) && !wp);
    return m;
  endfunction

  task automatic doReset(input bit top);
    @(negedge clk);
    rst_n = 1'b0;
    bootTopStrap = top;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    bootTopStrap = !top;  // strap must only matter while in reset
    @(negedge clk);
    check(!opEnable && !protectErr && !sweepBusy && !sweepDone && eraseStrobe == '0,
          "R8 reset state", int'({opEnable, protectErr, sweepBusy, sweepDone}), 0);
  endtask

  // runs one request from a negedge and returns at a negedge with the block idle
  task automatic runReq(input bit top, input int op, input int blk,
                        input logic [NB-1:0] locks, input bit wp, input bit perm,
                        input bit sl, input bit rp);
    bit gate;
    bit allow;
    bit known;
    logic [NB-1:0] em;
    string tag;
    gate  = !sl && rp;
    known = op <= 5;
    em    = gate ? expErasable(top, wp, locks) : '0;
    case (op)
      0, 1: allow = gate && !locks[blk] && !(isBoot(blk, top) && !wp);
      2:    allow = em != '0;
      3, 4: allow = gate && !perm;
      5:    allow = gate;
      default: allow = 1'b0;
    endcase
    if (!known) tag = "R11 unused op";
    else if (sl) tag = "R2 lockout";
    else if (!rp) tag = "R3 reset pin";
    else if (op <= 1) tag = (!locks[blk] && !isBoot(blk, top) && !wp) ? "R1 wp non-boot"
                          : (!locks[blk] && isBoot(blk, top)) ? "R1 boot wp" : "R4 lock-bit";
    else if (op == 2) tag = allow ? "R5 chip erase" : "R10 nothing erasable";
    else if (op <= 4) tag = "R6 perm gate";
    else tag = "R7 set perm";

    reqOp = 3'(op); reqBlock = BW'(blk); blockLocks = locks;
    wpN = wp; permLock = perm; supplyLow = sl; resetPinN = rp;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(opEnable == (known && allow), {tag, " enable"}, int'(opEnable), int'(known && allow));
    check(protectErr == (known && !allow), {tag, " error"}, int'(protectErr), int'(known && !allow));
    if (op == 2 && allow) begin
      for (int k = 0; k < NB; k++) begin
        logic [NB-1:0] es;
        es = em[k] ? (NB'(1) << k) : '0;
        check(eraseStrobe == es && sweepBusy, "R5 sweep strobe", int'(eraseStrobe), int'(es));
        @(negedge clk);
      end
      check(sweepDone && !sweepBusy, "R9 done pulse", int'({sweepDone, sweepBusy}), 2);
      @(negedge clk);
      check(!sweepDone, "R9 done single", int'(sweepDone), 0);
    end else begin
      check(!sweepBusy && eraseStrobe == '0, op == 2 ? "R10 no sweep" : "R8 no sweep",
            int'(eraseStrobe), 0);
    end
  endtask

  initial begin
    logic [NB-1:0] pats [3];
    pats[0] = '0;
    pats[1] = NB'(8'h5A);
    pats[2] = '1;
    for (int top = 0; top < 2; top++) begin
      doReset(top[0]);
      for (int op = 0; op < 8; op++)
        for (int blk = 0; blk < NB; blk++)
          for (int p = 0; p < 3; p++)
            for (int v = 0; v < 16; v++)
              runReq(top[0], op, blk, pats[p], v[0], v[1], v[2], v[3]);
    end

    // R12: abort mid-sweep (top configuration from the last reset)
    runReqAbort();
    // R11: request during sweep is dropped
    runBusyIgnore();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  task automatic runReqAbort();
    blockLocks = '0; wpN = 1'b1; permLock = 1'b0; supplyLow = 1'b0; resetPinN = 1'b1;
    reqOp = 3'd2; reqValid = 1'b1;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check(opEnable, "R5 abort setup enable", int'(opEnable), 1);
    for (int k = 0; k < 3; k++) begin
      check(eraseStrobe == (NB'(1) << k), "R5 pre-abort strobe", int'(eraseStrobe), 1 << k);
      @(negedge clk);
    end
    supplyLow = 1'b1;
    #1;
    check(eraseStrobe == '0, "R12 strobe drops", int'(eraseStrobe), 0);
    @(negedge clk);
    check(protectErr && !sweepBusy && !sweepDone, "R12 abort error",
          int'({protectErr, sweepBusy, sweepDone}), 4);
    supplyLow = 1'b0;
    for (int k = 0; k < NB; k++) begin
      @(negedge clk);
      check(!sweepDone && eraseStrobe == '0, "R12 no done after abort", int'(sweepDone), 0);
    end
  endtask

  task automatic runBusyIgnore();
    blockLocks = '0; wpN = 1'b1;
    reqOp = 3'd2; reqValid = 1'b1;
    @(posedge clk); @(negedge clk);
    reqOp = 3'd0; reqBlock = BW'(3); reqValid = 1'b1;
    check(eraseStrobe == NB'(1), "R5 busy test idx0", int'(eraseStrobe), 1);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check(!opEnable && !protectErr, "R11 busy ignore", int'({opEnable, protectErr}), 0);
    check(eraseStrobe == NB'(2), "R11 sweep continues", int'(eraseStrobe), 2);
    for (int k = 2; k < NB; k++) @(negedge clk);
    @(negedge clk);
    check(sweepDone, "R9 done after busy test", int'(sweepDone), 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule